// File: doc/BRIEF.md
# Variable-Length Receive Frame FIFO

This block buffers accepted receive frames for a bus controller in a shared 64-byte circular byte store. It does not use fixed-width slots. Each frame is kept as a record of header bytes followed by its data bytes.

- The receive path appends the bytes of one frame through a write port. A commit strobe then makes the record visible. An abort strobe throws the partial record away.
- The host sees the oldest record through an indexed window that starts at the read pointer and wraps past the end of the store. A release strobe discards that record.
- The record length is decoded from the header. It depends on the window format selected by `ext_mode` (compact or extended) and on the header fields.
- Because records vary in size, the number of frames held varies too, up to a limit of 32.

A message counter, a data-available flag and a sticky overrun flag report occupancy. A second read port returns any byte of the store by absolute offset, for diagnostics.

Top module: `rxf_msg_fifo`

## Requirements
- R1: After reset, `msg_count` is 0, `data_avail` is 0 and `overrun` is 0.
- R2: Record length is computed from the header as follows. The data part is 0 when the remote flag is set, otherwise min(DLC, 8).
  - Compact format (`ext_mode`=0): length is 2 plus the data part. The second byte carries the remote flag in bit 4 and the DLC in bits 3:0.
  - Extended format (`ext_mode`=1): length is 1 plus an identifier part plus the data part. The first byte carries the long-identifier flag in bit 7, the remote flag in bit 6 and the DLC in bits 3:0. The identifier part is 4 when bit 7 is set, otherwise 2.
- R3: A commit stores the pending bytes in consecutive order from the write pointer, modulo 64. `msg_count` rises by one in the cycle after the commit edge. The write pointer moves only on a commit.
- R4: A commit is rejected when any of these holds: the pending bytes exceed the free space, more than 13 bytes are pending, or `msg_count` is already 32. On a rejected commit, the count and the read side are unchanged and `overrun` is 1 from the next cycle.
- R5: `clr_overrun` clears `overrun` at the next edge, unless a commit is rejected in the same cycle.
- R6: For `win_idx` below the window size, `win_data` is the byte at (read pointer + `win_idx`) mod 64. The window size is 10 in the compact format and 13 in the extended format. At or above the window size, `win_data` is 0.
- R7: A release advances the read pointer by the oldest record's length and lowers `msg_count` by one. A release with `msg_count` 0 is ignored.
- R8: `data_avail` is 1 exactly when `msg_count` is nonzero.
- R9: `wr_abort` drops the pending bytes, leaving count, overrun and stored records unchanged. A commit with no pending bytes does nothing.
- R10: `raw_data` is the stored byte at absolute offset `raw_addr`.
- R11: A commit and a release in the same cycle both take effect, so `msg_count` keeps its value. Free space for that commit is judged before the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 1 selects the extended record format and 13-byte window |
| wr_valid | input | 1 | Append `wr_byte` to the pending record |
| wr_byte | input | 8 | Byte to append |
| wr_commit | input | 1 | Make the pending record visible (or reject it) |
| wr_abort | input | 1 | Drop the pending record |
| rd_release | input | 1 | Discard the oldest record |
| clr_overrun | input | 1 | Clear the overrun flag |
| win_idx | input | 4 | Byte index into the oldest record |
| win_data | output | 8 | Window byte, combinational |
| raw_addr | input | 6 | Absolute byte offset |
| raw_data | output | 8 | Byte at `raw_addr`, combinational |
| msg_count | output | 6 | Records held |
| data_avail | output | 1 | At least one record held |
| overrun | output | 1 | Sticky: a frame was lost |

## Verification
The strobes (commit, abort, release, clear) are sampled at a rising edge. Their effects appear on `msg_count`, `data_avail`, `overrun` and the window one edge later. The window and raw ports are combinational from that state.

The bench drives every strobe for exactly one cycle, starting just after a falling edge. It checks at the next falling edge, which is the first point where the result is due. The window and raw bytes are swept index by index while no strobe is active, so the state under them cannot move.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
  localparam int unsigned WIN_COMPACT = 10;
  localparam int unsigned WIN_EXTENDED = 13;
  localparam int unsigned MAX_DATA = 8;

  typedef logic [4:0] len_t;

  // data part of a record: none for remote frames, DLC clamped to 8
  function automatic len_t data_part(input logic remote, input logic [3:0] dlc);
    if (remote) return '0;
    if (dlc > 4'd8) return len_t'(MAX_DATA);
    return {1'b0, dlc};
  endfunction

  // full record length decoded from the first two header bytes
  function automatic len_t record_len(input logic ext, input logic [7:0] h0,
                                      input logic [7:0] h1);
    len_t head;
    if (ext) begin
      head = h0[7] ? 5'd5 : 5'd3;
      return head + data_part(h0[6], h0[3:0]);
    end
    return 5'd2 + data_part(h1[4], h1[3:0]);
  endfunction

  function automatic len_t window_size(input logic ext);
    return ext ? len_t'(WIN_EXTENDED) : len_t'(WIN_COMPACT);
  endfunction
endpackage

// File: rtl/rxf_ram.sv
`timescale 1ns/1ps
module rxf_ram #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] a_raw,
  input  logic [AW-1:0] a_win,
  input  logic [AW-1:0] a_h0,
  input  logic [AW-1:0] a_h1,
  output logic [7:0]    d_raw,
  output logic [7:0]    d_win,
  output logic [7:0]    d_h0,
  output logic [7:0]    d_h1
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign d_raw = mem[a_raw];
  assign d_win = mem[a_win];
  assign d_h0  = mem[a_h0];
  assign d_h1  = mem[a_h1];
endmodule

// File: rtl/rxf_wr_ctrl.sv
`timescale 1ns/1ps
module rxf_wr_ctrl
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned AW     = 6,
  parameter int unsigned FILLW  = 7,
  parameter int unsigned MAXREC = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [7:0]       wr_byte,
  input  logic             wr_commit,
  input  logic             wr_abort,
  input  logic [FILLW-1:0] fill,
  input  logic             msg_full,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic [7:0]       wdata,
  output logic             commit_ok,
  output logic             commit_rej,
  output len_t             commit_len
);
  logic [AW-1:0]    wptr;
  len_t             wcnt;
  logic             bad;
  logic [FILLW-1:0] free_bytes;
  logic             byte_take;
  logic             byte_fits;

  assign free_bytes = FILLW'(DEPTH) - fill;
  assign byte_take  = wr_valid && !wr_commit && !wr_abort;
  assign byte_fits  = (wcnt < len_t'(MAXREC)) && (FILLW'(wcnt) < free_bytes);

  assign we    = byte_take && byte_fits && !bad;
  assign waddr = wptr + AW'(wcnt);
  assign wdata = wr_byte;

  assign commit_ok  = wr_commit && !bad && !msg_full && (wcnt != '0);
  assign commit_rej = wr_commit && (bad || (msg_full && (wcnt != '0)));
  assign commit_len = wcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      wcnt <= '0;
      bad  <= 1'b0;
    end else if (wr_commit || wr_abort) begin
      if (commit_ok) wptr <= wptr + AW'(wcnt);
      wcnt <= '0;
      bad  <= 1'b0;
    end else if (byte_take && !bad) begin
      if (byte_fits) wcnt <= wcnt + 5'd1;
      else           bad  <= 1'b1;
    end
  end
endmodule

// File: rtl/rxf_rd_ctrl.sv
`timescale 1ns/1ps
module rxf_rd_ctrl
  import rxf_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_mode,
  input  logic          rd_release,
  input  logic          msg_empty,
  input  logic [7:0]    h0,
  input  logic [7:0]    h1,
  input  logic [3:0]    win_idx,
  output logic [AW-1:0] a_h0,
  output logic [AW-1:0] a_h1,
  output logic [AW-1:0] a_win,
  output logic          win_valid,
  output logic          release_go,
  output len_t          rel_len
);
  logic [AW-1:0] rptr;

  assign a_h0       = rptr;
  assign a_h1       = rptr + AW'(1);
  assign a_win      = rptr + AW'(win_idx);
  assign win_valid  = len_t'(win_idx) < window_size(ext_mode);
  assign release_go = rd_release && !msg_empty;
  assign rel_len    = record_len(ext_mode, h0, h1);

  always_ff @(posedge clk) begin
    if (!rst_n)          rptr <= '0;
    else if (release_go) rptr <= rptr + AW'(rel_len);
  end
endmodule

// File: rtl/rxf_msg_fifo.sv
`timescale 1ns/1ps
module rxf_msg_fifo
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH    = 64,
  parameter int unsigned MAX_MSGS = 32,
  parameter int unsigned MAXREC   = 13,
  localparam int unsigned AW      = $clog2(DEPTH),
  localparam int unsigned FILLW   = $clog2(DEPTH + 1),
  localparam int unsigned CNTW    = $clog2(MAX_MSGS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_mode,
  input  logic            wr_valid,
  input  logic [7:0]      wr_byte,
  input  logic            wr_commit,
  input  logic            wr_abort,
  input  logic            rd_release,
  input  logic            clr_overrun,
  input  logic [3:0]      win_idx,
  output logic [7:0]      win_data,
  input  logic [AW-1:0]   raw_addr,
  output logic [7:0]      raw_data,
  output logic [CNTW-1:0] msg_count,
  output logic            data_avail,
  output logic            overrun
);
  logic [CNTW-1:0]  count_q;
  logic [FILLW-1:0] fill_q;
  logic             ovf_q;

  // named internal events, observed by the bound checker
  logic          commit_ok, commit_rej, release_go, win_valid, we;
  len_t          commit_len, rel_len;
  logic [AW-1:0] waddr, a_h0, a_h1, a_win;
  logic [7:0]    wdata, d_h0, d_h1, d_win;
  logic          msg_full, msg_empty;

  assign msg_full  = (count_q == CNTW'(MAX_MSGS));
  assign msg_empty = (count_q == '0);

  rxf_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .a_raw(raw_addr), .a_win(a_win), .a_h0(a_h0), .a_h1(a_h1),
    .d_raw(raw_data), .d_win(d_win), .d_h0(d_h0), .d_h1(d_h1)
  );

  rxf_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .FILLW(FILLW), .MAXREC(MAXREC)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_byte(wr_byte),
    .wr_commit(wr_commit), .wr_abort(wr_abort), .fill(fill_q),
    .msg_full(msg_full), .we(we), .waddr(waddr), .wdata(wdata),
    .commit_ok(commit_ok), .commit_rej(commit_rej), .commit_len(commit_len)
  );

  rxf_rd_ctrl #(.AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .rd_release(rd_release),
    .msg_empty(msg_empty), .h0(d_h0), .h1(d_h1), .win_idx(win_idx),
    .a_h0(a_h0), .a_h1(a_h1), .a_win(a_win), .win_valid(win_valid),
    .release_go(release_go), .rel_len(rel_len)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      fill_q  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      count_q <= count_q + CNTW'(commit_ok) - CNTW'(release_go);
      fill_q  <= fill_q + (commit_ok ? FILLW'(commit_len) : '0)
                        - (release_go ? FILLW'(rel_len) : '0);
      if (commit_rej)       ovf_q <= 1'b1;
      else if (clr_overrun) ovf_q <= 1'b0;
    end
  end

  assign win_data   = win_valid ? d_win : 8'h00;
  assign msg_count  = count_q;
  assign data_avail = !msg_empty;
  assign overrun    = ovf_q;
endmodule

// File: rtl/rxf_msg_fifo_chk.sv
`timescale 1ns/1ps
module rxf_msg_fifo_chk
  import rxf_pkg::*;
#(
  parameter int unsigned MAX_MSGS = 32,
  parameter int unsigned CNTW     = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            commit_ok,
  input logic            commit_rej,
  input logic            release_go,
  input len_t            rel_len,
  input logic            rd_release,
  input logic            clr_overrun,
  input logic [CNTW-1:0] msg_count,
  input logic            overrun,
  input logic            data_avail
);
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_count <= CNTW'(MAX_MSGS));
  assert_reject_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_rej |=> overrun);
  assert_reject_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_rej && !release_go) |=> $stable(msg_count));
  assert_commit_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ok && !release_go) |=> msg_count == $past(msg_count) + CNTW'(1));
  assert_release_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (release_go && !commit_ok) |=> msg_count == $past(msg_count) - CNTW'(1));
  assert_empty_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_release && msg_count == '0 && !commit_ok) |=> msg_count == '0);
  assert_len_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    release_go |-> (rel_len >= 5'd2 && rel_len <= 5'd13));
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_overrun && !commit_rej) |=> !overrun);
  assert_avail_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (release_go && !commit_ok && msg_count == CNTW'(1)) |=> !data_avail);
  assert_both_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ok && release_go) |=> $stable(msg_count));
endmodule

bind rxf_msg_fifo rxf_msg_fifo_chk #(.MAX_MSGS(MAX_MSGS), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .commit_ok(commit_ok), .commit_rej(commit_rej),
  .release_go(release_go), .rel_len(rel_len), .rd_release(rd_release),
  .clr_overrun(clr_overrun), .msg_count(msg_count), .overrun(overrun),
  .data_avail(data_avail)
);

// File: tb/tb_rxf_msg_fifo.sv
`timescale 1ns/1ps
module tb_rxf_msg_fifo;
  logic       clk = 0, rst_n = 0, ext_mode = 0;
  logic       wr_valid = 0, wr_commit = 0, wr_abort = 0, rd_release = 0, clr_overrun = 0;
  logic [7:0] wr_byte = 0;
  logic [3:0] win_idx = 0;
  logic [5:0] raw_addr = 0;
  logic [7:0] win_data, raw_data;
  logic [5:0] msg_count;
  logic       data_avail, overrun;

  int errors = 0, checks = 0;
  bit [7:0] mem_m [64];
  bit [7:0] fb [16];
  int m_wp = 0, m_rp = 0, m_fill = 0, m_cnt = 0;
  bit m_ovf = 0;
  logic [15:0] lfsr = 16'hACE1;

  rxf_msg_fifo dut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .wr_valid(wr_valid),
    .wr_byte(wr_byte), .wr_commit(wr_commit), .wr_abort(wr_abort),
    .rd_release(rd_release), .clr_overrun(clr_overrun), .win_idx(win_idx),
    .win_data(win_data), .raw_addr(raw_addr), .raw_data(raw_data),
    .msg_count(msg_count), .data_avail(data_avail), .overrun(overrun)
  );

  always #2.5 clk = ~clk;

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // length rule restated from the requirement text
  function automatic int blen(input bit ext, input bit [7:0] b0, input bit [7:0] b1);
    int d;
    int lim_hdr;
    if (ext) begin
      d = b0[6] ? 0 : ((int'(b0[3:0]) > 8) ? 8 : int'(b0[3:0]));
      lim_hdr = b0[7] ? 5 : 3;
      return lim_hdr + d;
    end
    d = b1[4] ? 0 : ((int'(b1[3:0]) > 8) ? 8 : int'(b1[3:0]));
    return 2 + d;
  endfunction

  task automatic make_frame(input bit longid, input bit rtr, input int dlc,
                            input int seed, output int n);
    for (int i = 0; i < 16; i++) fb[i] = 8'((seed * 7 + i * 13 + 1) & 255);
    if (ext_mode) fb[0] = {longid, rtr, 2'b00, 4'(dlc)};
    else          fb[1] = {fb[1][7:5], rtr, 4'(dlc)};
    n = blen(ext_mode, fb[0], fb[1]);
  endtask

  task automatic push(input bit [7:0] b);
    wr_valid = 1; wr_byte = b;
    @(negedge clk);
    wr_valid = 0;
  endtask

  function automatic bit fits(input int n);
    return !(m_cnt == 32 || n > 13 || n > 64 - m_fill);
  endfunction

  task automatic model_commit(input int n);
    if (n == 0) return;
    if (!fits(n)) begin m_ovf = 1; return; end
    for (int i = 0; i < n; i++) mem_m[(m_wp + i) % 64] = fb[i];
    m_wp = (m_wp + n) % 64; m_fill += n; m_cnt++;
  endtask

  task automatic check_status(input string req);
    chk({req, " msg_count"}, int'(msg_count), m_cnt);
    chk({req, " overrun"}, int'(overrun), int'(m_ovf));
    chk("R8 data_avail", int'(data_avail), int'(m_cnt != 0));
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) push(fb[i]);
    wr_commit = 1;
    @(negedge clk);
    wr_commit = 0;
    model_commit(n);
    check_status("R3/R4 commit");
  endtask

  task automatic check_window;
    int len, lim;
    len = blen(ext_mode, mem_m[m_rp], mem_m[(m_rp + 1) % 64]);
    lim = ext_mode ? 13 : 10;
    for (int i = 0; i < len; i++) begin
      win_idx = 4'(i); raw_addr = 6'((m_rp + i) % 64);
      #0.5;
      chk("R6 window byte", int'(win_data), int'(mem_m[(m_rp + i) % 64]));
      chk("R10 raw byte", int'(raw_data), int'(mem_m[(m_rp + i) % 64]));
    end
    win_idx = 4'(lim); #0.5;
    chk("R6 beyond window", int'(win_data), 0);
    win_idx = 4'd15; #0.5;
    chk("R6 top index", int'(win_data), 0);
    @(negedge clk);
  endtask

  task automatic release_one;
    int len;
    if (m_cnt > 0) check_window();
    rd_release = 1;
    @(negedge clk);
    rd_release = 0;
    if (m_cnt > 0) begin
      len = blen(ext_mode, mem_m[m_rp], mem_m[(m_rp + 1) % 64]);
      m_rp = (m_rp + len) % 64; m_fill -= len; m_cnt--;
    end
    check_status("R7 release");
  endtask

  task automatic clear_ovf;
    clr_overrun = 1;
    @(negedge clk);
    clr_overrun = 0;
    m_ovf = 0;
    chk("R5 overrun cleared", int'(overrun), 0);
  endtask

  task automatic drain;
    while (m_cnt > 0) release_one();
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset count", int'(msg_count), 0);
    chk("R1 reset avail", int'(data_avail), 0);
    chk("R1 reset overrun", int'(overrun), 0);

    // R2 compact format: every remote flag and DLC
    ext_mode = 0;
    for (int r = 0; r < 2; r++)
      for (int d = 0; d < 16; d++) begin
        make_frame(0, r[0], d, r * 16 + d, n); send(n); release_one();
      end

    // R2 extended format: both identifier sizes
    ext_mode = 1;
    for (int e = 0; e < 2; e++)
      for (int r = 0; r < 2; r++)
        for (int d = 0; d < 16; d++) begin
          make_frame(e[0], r[0], d, e * 32 + r * 16 + d, n); send(n); release_one();
        end

    // R4 count limit with 2-byte compact records
    ext_mode = 0;
    for (int k = 0; k < 33; k++) begin make_frame(0, 1, 0, k, n); send(n); end
    chk("R4 count capped", int'(msg_count), 32);
    chk("R4 overrun on 33rd", int'(overrun), 1);
    drain();
    clear_ovf();

    // R4 space limit and R6 wrap with 13-byte records
    ext_mode = 1;
    for (int k = 0; k < 5; k++) begin make_frame(1, 0, 8, 40 + k, n); send(n); end
    chk("R4 space reject", int'(overrun), 1);
    release_one(); release_one();
    clear_ovf();
    for (int k = 0; k < 2; k++) begin make_frame(1, 0, 8, 60 + k, n); send(n); end
    drain();

    // R4 oversize pending record
    for (int i = 0; i < 14; i++) push(8'(i));
    wr_commit = 1; @(negedge clk); wr_commit = 0;
    m_ovf = 1;
    check_status("R4 oversize");
    clear_ovf();

    // R9 abort and empty commit
    push(8'h11); push(8'h22); push(8'h33);
    wr_abort = 1; @(negedge clk); wr_abort = 0;
    check_status("R9 abort");
    wr_commit = 1; @(negedge clk); wr_commit = 0;
    check_status("R9 empty commit");
    make_frame(0, 0, 3, 90, n); send(n); release_one();

    // R7 release when empty
    release_one();
    chk("R7 empty release", int'(msg_count), 0);

    // R11 commit and release in the same cycle
    make_frame(1, 0, 2, 91, n); send(n);
    make_frame(0, 0, 5, 92, n);
    check_window();
    for (int i = 0; i < n; i++) push(fb[i]);
    wr_commit = 1; rd_release = 1;
    @(negedge clk);
    wr_commit = 0; rd_release = 0;
    begin
      int ol;
      ol = blen(1, mem_m[m_rp], mem_m[(m_rp + 1) % 64]);
      model_commit(n);
      m_rp = (m_rp + ol) % 64; m_fill -= ol; m_cnt--;
    end
    chk("R11 count held", int'(msg_count), 1);
    drain();

    // mixed traffic in extended format
    for (int it = 0; it < 400; it++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0] || m_cnt == 0) begin
        make_frame(lfsr[1], lfsr[2] & lfsr[3], int'(lfsr[7:4]), it, n); send(n);
      end else release_one();
      if (m_ovf) clear_ovf();
    end
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule